// File: doc/BRIEF.md
# Paired Half-Precision Compare-to-Mask Unit

This block takes two 32-bit words, each holding two half-precision values, and compares them lane by lane. Lane 0 is the low 16 bits of both words and lane 1 is the high 16 bits. A 3-bit condition code selects the comparison. Each lane's outcome is then merged with one external predicate bit through a 2-bit boolean operation. The predicate bit can be inverted before the merge.

A lane whose merged result is true writes its true pattern into its own half of the result word. A lane whose result is false writes zero there. A format flag chooses the true pattern: half-precision 1.0 (0x3C00) when set, all-ones (0xFFFF) when clear. The callers that shape the operands and store the predicate bits sit upstream and are not part of this block.

Operands enter through a valid/ready stream and the mask leaves through a second valid/ready stream after one register stage. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word and its valid bit stay frozen and no new input is taken.

Top module: `hcm_mask_unit`

## Requirements
- R1: Lane 0 uses bits 15:0 of both operands and writes bits 15:0 of the mask. Lane 1 uses bits 31:16 and writes bits 31:16. The two lanes never influence each other.
- R2: Condition codes: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always. They apply to the IEEE half-precision ordering of the lane values, including infinities.
- R3: A value is NaN when its exponent field (bits 14:10) is all ones and its fraction (bits 9:0) is nonzero. If either lane input is NaN, codes 1, 2, 3, 4 and 6 give false, while codes 5 and 7 give true.
- R4: +0 (0x0000) and -0 (0x8000) compare as equal, and neither is less than the other.
- R5: The combine code merges the lane outcome with the effective predicate bit: 0 AND, 1 OR, 2 XOR. The reserved code 3 acts as AND.
- R6: The effective predicate is `pred_val` XOR `pred_inv`.
- R7: A true lane writes 0x3C00 when `fmt_one` is 1 and 0xFFFF when it is 0. A false lane writes 0x0000.
- R8: An accepted input appears on `out_mask` with `out_valid` high after the next clock edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, `out_mask` and `out_valid` hold their values.
- R9: During and directly after reset, `out_valid` is 0 and `out_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand word valid |
| in_ready | output | 1 | Unit can take an operand word |
| op_a | input | 32 | First operand, two half lanes |
| op_b | input | 32 | Second operand, two half lanes |
| cond | input | 3 | Comparison code (R2) |
| comb_op | input | 2 | Combine code (R5) |
| pred_val | input | 1 | External predicate bit |
| pred_inv | input | 1 | Invert the predicate before combining |
| fmt_one | input | 1 | True pattern select: 1 gives 0x3C00, 0 gives 0xFFFF |
| out_valid | output | 1 | Mask word valid |
| out_ready | input | 1 | Consumer takes the mask word |
| out_mask | output | 32 | Result mask, one 16-bit field per lane |

## Verification
The vector table gives the two lanes opposite orderings, so that a swapped or shared lane shows up as a mirrored mask. Every condition code is applied to pairs that are less, equal and greater, including negative values, where a plain unsigned compare would get the order wrong. Further vectors cover NaN inputs (ordered codes against not-equal and always), signed zeros, and infinities against the largest finite value. The combine and invert vectors hold the compare outcome fixed and walk the predicate, so that each boolean operation, including the reserved code, produces a distinct mask. Directed tests then stall the output to check the hold and ready rules.

// File: rtl/hcm_pkg.sv
package hcm_pkg;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned EXP_W   = 5;
  localparam int unsigned MAN_W   = 10;
  localparam int unsigned LANES   = 2;
  localparam int unsigned WORD_W  = HALF_W * LANES;
  localparam int unsigned COND_W  = 3;
  localparam int unsigned COMB_W  = 2;

  localparam logic [HALF_W-1:0] PAT_ONE  = 16'h3C00;
  localparam logic [HALF_W-1:0] PAT_ALL  = {HALF_W{1'b1}};

  // Condition codes: bit 0 = less, bit 1 = equal, bit 2 = greater
  localparam logic [COND_W-1:0] C_NEVER = 3'd0;
  localparam logic [COND_W-1:0] C_LT    = 3'd1;
  localparam logic [COND_W-1:0] C_NE    = 3'd5;
  localparam logic [COND_W-1:0] C_ALWAYS = 3'd7;

  typedef enum logic [COMB_W-1:0] {
    CMB_AND  = 2'd0,
    CMB_OR   = 2'd1,
    CMB_XOR  = 2'd2,
    CMB_RSVD = 2'd3
  } comb_e;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic unord;
  } rel_t;

  function automatic logic half_is_nan(input logic [HALF_W-1:0] v);
    return (&v[HALF_W-2 -: EXP_W]) && (|v[MAN_W-1:0]);
  endfunction

  function automatic logic half_is_zero(input logic [HALF_W-1:0] v);
    return ~|v[HALF_W-2:0];
  endfunction

  // Map sign-magnitude to an unsigned key that orders like the real value
  function automatic logic [HALF_W-1:0] half_key(input logic [HALF_W-1:0] v);
    return v[HALF_W-1] ? ~v : (v | {1'b1, {(HALF_W-1){1'b0}}});
  endfunction
endpackage

// File: rtl/hcm_lane_cmp.sv
module hcm_lane_cmp
  import hcm_pkg::*;
#(
  parameter int unsigned W = HALF_W
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [COND_W-1:0] cond,
  output rel_t              rel,
  output logic              hit
);
  logic a_nan, b_nan, both_zero;
  logic [W-1:0] key_a, key_b;

  always_comb begin
    a_nan     = half_is_nan(a);
    b_nan     = half_is_nan(b);
    both_zero = half_is_zero(a) && half_is_zero(b);
    key_a     = half_key(a);
    key_b     = half_key(b);

    rel.unord = a_nan || b_nan;
    rel.eq    = !rel.unord && (both_zero || (a == b));
    rel.lt    = !rel.unord && !both_zero && (key_a < key_b);
    rel.gt    = !rel.unord && !both_zero && (key_a > key_b);

    if (rel.unord)
      hit = (cond == C_NE) || (cond == C_ALWAYS);
    else
      hit = |(cond & {rel.gt, rel.eq, rel.lt});
  end

  // p_one_relation_r2: an ordered pair is in exactly one relation
  always_comb begin
    if (!rel.unord)
      p_one_relation_r2: assert ($onehot({rel.lt, rel.eq, rel.gt}))
        else $error("R2 ordered pair not in exactly one relation");
  end

  // p_nan_ordered_false_r3: NaN fails every ordered test
  always_comb begin
    if ((a_nan || b_nan) && cond != C_NE && cond != C_ALWAYS)
      p_nan_ordered_false_r3: assert (!hit)
        else $error("R3 NaN passed an ordered compare");
  end

  // p_zero_equal_r4: signed zeros are equal
  always_comb begin
    if (half_is_zero(a) && half_is_zero(b))
      p_zero_equal_r4: assert (rel.eq && !rel.lt && !rel.gt)
        else $error("R4 signed zeros not equal");
  end
endmodule

// File: rtl/hcm_lane_fold.sv
module hcm_lane_fold
  import hcm_pkg::*;
#(
  parameter int unsigned W = HALF_W
) (
  input  logic              hit,
  input  logic [COMB_W-1:0] comb_op,
  input  logic              pred,
  input  logic              fmt_one,
  output logic [W-1:0]      lane_out
);
  logic merged;
  logic [W-1:0] pattern;

  always_comb begin
    unique case (comb_e'(comb_op))
      CMB_OR:   merged = hit | pred;
      CMB_XOR:  merged = hit ^ pred;
      default:  merged = hit & pred;
    endcase
    pattern  = fmt_one ? PAT_ONE : PAT_ALL;
    lane_out = merged ? pattern : '0;
  end

  // p_lane_pattern_r7: a lane is either zero or the chosen true pattern
  always_comb begin
    p_lane_pattern_r7: assert (lane_out == '0 ||
                               lane_out == (fmt_one ? PAT_ONE : PAT_ALL))
      else $error("R7 lane word is not a legal pattern");
  end

  // p_and_dominates_r5: AND-like codes with a false predicate yield zero
  always_comb begin
    if ((comb_op == CMB_AND || comb_op == CMB_RSVD) && !pred)
      p_and_dominates_r5: assert (lane_out == '0)
        else $error("R5 AND with false predicate wrote nonzero");
  end
endmodule

// File: rtl/hcm_out_stage.sv
module hcm_out_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data))
    else $error("R8 output changed while stalled");

  p_accept_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid)
    else $error("R8 accepted word did not appear");

  p_drain_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid)
    else $error("R8 drained word still valid");
endmodule

// File: rtl/hcm_mask_unit.sv
module hcm_mask_unit
  import hcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic [COND_W-1:0] cond,
  input  logic [COMB_W-1:0] comb_op,
  input  logic              pred_val,
  input  logic              pred_inv,
  input  logic              fmt_one,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_mask
);
  logic              pred_eff;
  logic [WORD_W-1:0] mask_next;

  assign pred_eff = pred_val ^ pred_inv;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rel_t lane_rel;
    logic lane_hit;
    logic [HALF_W-1:0] lane_word;

    hcm_lane_cmp #(.W(HALF_W)) u_cmp (
      .a    (op_a[g*HALF_W +: HALF_W]),
      .b    (op_b[g*HALF_W +: HALF_W]),
      .cond (cond),
      .rel  (lane_rel),
      .hit  (lane_hit)
    );

    hcm_lane_fold #(.W(HALF_W)) u_fold (
      .hit      (lane_hit),
      .comb_op  (comb_op),
      .pred     (pred_eff),
      .fmt_one  (fmt_one),
      .lane_out (lane_word)
    );

    assign mask_next[g*HALF_W +: HALF_W] = lane_word;
  end

  hcm_out_stage #(.W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (mask_next),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_mask)
  );

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !$past(out_valid) && !$past(in_valid) |-> out_mask == $past(out_mask))
    else $error("R9 idle mask changed");
endmodule

// File: tb/hcm_mask_unit_bench.sv
module hcm_mask_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  // row: {a, b, cond, comb, pred_val, pred_inv, fmt, expected}
  localparam logic [103:0] VEC [NV] = '{
    {32'h40003C00, 32'h3C004000, 3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0000FFFF}, // R1 R2 lt
    {32'h40003C00, 32'h3C004000, 3'd4, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFF0000}, // R1 R2 gt
    {32'h3C003C00, 32'h3C004000, 3'd2, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFF0000}, // R2 eq
    {32'h3C003C00, 32'h3C004000, 3'd3, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF}, // R2 le
    {32'h3C003C00, 32'h3C004000, 3'd6, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFF0000}, // R2 ge
    {32'h3C003C00, 32'h3C004000, 3'd5, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0000FFFF}, // R2 ne
    {32'h3C003C00, 32'h3C004000, 3'd0, 2'd1, 1'b0, 1'b0, 1'b0, 32'h00000000}, // R2 never
    {32'h3C003C00, 32'h3C004000, 3'd7, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF}, // R2 always
    {32'hBC00C000, 32'h3C00BC00, 3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF}, // R2 negatives
    {32'hC000BC00, 32'hBC00C000, 3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFF0000}, // R2 negatives
    {32'h7C00FC00, 32'h7BFF0000, 3'd4, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFF0000}, // R2 infinities
    {32'h7E007E00, 32'h3C007E00, 3'd3, 2'd1, 1'b0, 1'b0, 1'b0, 32'h00000000}, // R3 le
    {32'h7E007E00, 32'h3C007E00, 3'd2, 2'd1, 1'b0, 1'b0, 1'b0, 32'h00000000}, // R3 eq
    {32'h7E003C00, 32'h3C007C01, 3'd6, 2'd1, 1'b0, 1'b0, 1'b0, 32'h00000000}, // R3 ge
    {32'h7E007E00, 32'h3C007E00, 3'd5, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF}, // R3 ne
    {32'h7E007E00, 32'h3C007E00, 3'd7, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF}, // R3 always
    {32'h80000000, 32'h00008000, 3'd2, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF}, // R4 eq
    {32'h80000000, 32'h00008000, 3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h00000000}, // R4 lt
    {32'h40003C00, 32'h3C004000, 3'd1, 2'd1, 1'b0, 1'b0, 1'b1, 32'h00003C00}, // R7 one
    {32'h40003C00, 32'h3C004000, 3'd1, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0000FFFF}, // R5 and p1
    {32'h40003C00, 32'h3C004000, 3'd7, 2'd0, 1'b0, 1'b0, 1'b0, 32'h00000000}, // R5 and p0
    {32'h40003C00, 32'h3C004000, 3'd1, 2'd1, 1'b1, 1'b0, 1'b0, 32'hFFFFFFFF}, // R5 or p1
    {32'h40003C00, 32'h3C004000, 3'd1, 2'd2, 1'b1, 1'b0, 1'b0, 32'hFFFF0000}, // R5 xor p1
    {32'h40003C00, 32'h3C004000, 3'd1, 2'd3, 1'b1, 1'b0, 1'b0, 32'h0000FFFF}, // R5 rsvd p1
    {32'h40003C00, 32'h3C004000, 3'd1, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0000FFFF}, // R6 and inv
    {32'h40003C00, 32'h3C004000, 3'd1, 2'd2, 1'b0, 1'b1, 1'b1, 32'h3C000000}, // R6 R7 xor inv
    {32'h40003C00, 32'h3C004000, 3'd1, 2'd1, 1'b1, 1'b1, 1'b0, 32'h0000FFFF}  // R6 or inv
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [2:0] cond = '0;
  logic [1:0] comb_op = '0;
  logic pred_val = 1'b0, pred_inv = 1'b0, fmt_one = 1'b0;
  logic in_ready, out_valid;
  logic [31:0] out_mask;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcm_mask_unit u_hcm_mask_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .cond(cond), .comb_op(comb_op),
    .pred_val(pred_val), .pred_inv(pred_inv), .fmt_one(fmt_one),
    .out_valid(out_valid), .out_ready(out_ready), .out_mask(out_mask)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [103:0] row);
    @(negedge clk);
    {op_a, op_b, cond, comb_op, pred_val, pred_inv, fmt_one} = row[103:32];
    in_valid = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset valid", {31'd0, out_valid}, 32'd0);
    check("R9 reset mask", out_mask, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    check("R8 ready when empty", {31'd0, in_ready}, 32'd1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      put(VEC[i]);
      @(posedge clk); #1;
      check($sformatf("vector %0d (R1-tagged row, see comment)", i), out_mask, VEC[i][31:0]);
      check("R8 valid after accept", {31'd0, out_valid}, 32'd1);
    end
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    check("R8 drain clears valid", {31'd0, out_valid}, 32'd0);

    // R8 back-pressure: stall output, offer a second word
    @(negedge clk); out_ready = 1'b0;
    put(VEC[0]);
    @(posedge clk); #1;
    check("R8 first word taken", out_mask, 32'h0000FFFF);
    put(VEC[1]);
    #1;
    check("R8 not ready while stalled", {31'd0, in_ready}, 32'd0);
    repeat (3) @(posedge clk);
    #1;
    check("R8 held while stalled", out_mask, 32'h0000FFFF);
    check("R8 valid held", {31'd0, out_valid}, 32'd1);
    @(negedge clk); out_ready = 1'b1;
    #1;
    check("R8 ready on drain", {31'd0, in_ready}, 32'd1);
    @(posedge clk); #1;
    check("R8 stalled word taken after release", out_mask, 32'hFFFF0000);
    @(negedge clk); in_valid = 1'b0;

    // R1 lane isolation: only high lane differs
    put({32'h3C004000, 32'h3C004000, 3'd2, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0});
    @(posedge clk); #1;
    check("R1 both lanes equal", out_mask, 32'hFFFFFFFF);
    put({32'h7E004000, 32'h3C004000, 3'd2, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0});
    @(posedge clk); #1;
    check("R1 high NaN leaves low lane", out_mask, 32'h0000FFFF);
    @(negedge clk); in_valid = 1'b0;

    // R9 reset mid-stream
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R9 async reset valid", {31'd0, out_valid}, 32'd0);
    check("R9 async reset mask", out_mask, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule